// File: doc/BRIEF.md
# Security Privilege State Tracker

This block keeps the live access rights of a secure memory. It holds three things: the communication mode (plain, authenticated or encrypted), the single active password set with its read or write right, and the key set chosen by the last accepted authentication. An external crypto engine reports its outcomes as one-cycle pulses: authentication, encryption activation, password verification and message-authentication checks. The tracker turns those pulses into state changes. It also keeps one attempt counter for each password set and one for each key set, and a counter at zero refuses every later attempt for its set.

Each memory zone states its own needs through configuration inputs: an optional password set, an optional key for authentication, and an optional demand for encryption. The memory controller puts a zone number on the query input and reads combinational read-allowed and write-allowed answers in the same cycle. The active-low reset plays the role of a card reset: it drops every privilege and reloads every attempt counter.

Top module: `sec_priv_tracker`

## Requirements
- R1: While `rst_n` is low and after it is released, `mode` is 0 (plain), `pw_valid` is 0 and every attempt counter holds `ATTEMPT_LIMIT`. This also clears any lockout reached before the reset.
- R2: The `mode` encoding is 0 plain, 1 authenticated, 2 encrypted. When `enc_done` arrives with `enc_ok` in mode 1 or 2, the next mode is 2. When `enc_done` arrives without `enc_ok` in mode 1 or 2, the next mode is 0. An `enc_done` in mode 0 leaves the mode at 0.
- R3: An accepted password attempt makes `pw_set` the only active set: `pw_valid`=1, `pw_active_set`=that set and `pw_write`=`pw_is_write`. It replaces any previously active set.
- R4: The write right includes the read right: a zone that is writable is also readable.
- R5: Zone z is bound to a password set when `zone_pw_req[z]`=1, and the set index is `zone_pw_set[3z+2:3z]`. Such a zone is readable only while its set is active. It is writable only while its set is active with the write right.
- R6: A password attempt that fails or is refused clears the active set (`pw_valid`=0).
- R7: Each password set and each key set has its own counter. A granted attempt reloads it to `ATTEMPT_LIMIT`. A failed attempt lowers it by one and stops at 0. At 0, even a correct attempt for that set is refused and treated as a failure.
- R8: A granted authentication gives mode 1 with `key_active`=`auth_key`, even when the mode was 2 before. A failed or refused authentication gives mode 0, even from mode 1 or 2.
- R9: While `sup_en`=1, the write right of set `sup_set` grants both read and write to every password-bound zone. The read right of that set grants nothing extra.
- R10: A MAC mismatch (`mac_done`=1, `mac_ok`=0) in mode 1 or 2 raises `cmd_abort` in the same cycle and returns the mode to 0. The password state is kept. A mismatch in mode 0 has no effect, and a MAC match has no effect.
- R11: A zone with `zone_auth_req[z]`=1 is reachable only in mode 1 or 2 with `key_active` equal to `zone_key[2z+1:2z]`. A zone with `zone_enc_req[z]`=1 is reachable only in mode 2 with that key.
- R12: Pulses in the same cycle are resolved in this order. An authentication outcome overrides both the MAC outcome and the encryption outcome. A MAC mismatch in mode 1 or 2 cancels a same-cycle encryption activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| auth_done | input | 1 | Authentication outcome pulse |
| auth_ok | input | 1 | Authentication succeeded |
| auth_key | input | 2 | Key set used by the authentication |
| enc_done | input | 1 | Encryption activation outcome pulse |
| enc_ok | input | 1 | Encryption activation succeeded |
| pw_done | input | 1 | Password verification outcome pulse |
| pw_ok | input | 1 | Password matched |
| pw_is_write | input | 1 | The presented password was the write password |
| pw_set | input | 3 | Password set presented |
| mac_done | input | 1 | MAC check outcome pulse |
| mac_ok | input | 1 | MAC matched |
| sup_en | input | 1 | Supervisor feature enabled |
| sup_set | input | 3 | Password set acting as supervisor |
| zone_pw_req | input | 8 | Per zone: password set required |
| zone_pw_set | input | 24 | Per zone: bound password set, 3 bits each |
| zone_auth_req | input | 8 | Per zone: authentication required |
| zone_key | input | 16 | Per zone: bound key set, 2 bits each |
| zone_enc_req | input | 8 | Per zone: encryption required |
| q_zone | input | 3 | Zone being queried |
| mode | output | 2 | Current mode (0 plain, 1 authenticated, 2 encrypted) |
| key_active | output | 2 | Key set of the last accepted authentication |
| pw_valid | output | 1 | A password set is active |
| pw_active_set | output | 3 | Active password set |
| pw_write | output | 1 | Active set holds the write right |
| cmd_abort | output | 1 | Current command is abandoned on a MAC mismatch |
| rd_allow | output | 1 | Queried zone may be read |
| wr_allow | output | 1 | Queried zone may be written |

## Verification
The MAC check and the authentication or encryption outcome can land in the same cycle, and their priority decides the resulting mode. The bench raises those pulses together from each starting mode: a mismatch with a granted authentication in encrypted mode, a mismatch with an encryption activation in authenticated mode, and an authentication with an encryption activation in plain mode. One cycle later it compares `mode` and `key_active` with the order stated in R12. It also sweeps every password set, both rights and every zone, and it drives each key set through the encrypted-zone checks and through counter exhaustion.

// File: rtl/sec_priv_pkg.sv
package sec_priv_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_AUTH = 2'd1,
    MODE_ENC  = 2'd2
  } sec_mode_e;
endpackage

// File: rtl/sec_attempt_bank.sv
// One saturating attempt counter per set; a counter at zero refuses attempts.
module sec_attempt_bank #(
  parameter int N     = 8,
  parameter int CW    = 4,
  parameter int LIMIT = 3,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int LW   = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          try_en,
  input  logic [IW-1:0] try_idx,
  input  logic          try_ok,
  output logic          grant
);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit;

    assign hit = try_en && (try_idx == IW'(i));

    always_comb begin
      cnt_d = cnt_q;
      if (try_ok && (cnt_q != '0)) begin
        cnt_d = LIMIT_V;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= LIMIT_V;
      end else if (hit) begin
        cnt_q <= cnt_d;
      end
    end

    assign live[i] = (cnt_q != '0);
  end

  logic [LW-1:0] live_ext;
  assign live_ext = LW'(live);
  assign grant    = try_en && try_ok && live_ext[try_idx];
endmodule

// File: rtl/sec_mode_fsm.sv
// Communication mode and active key set.
module sec_mode_fsm
  import sec_priv_pkg::*;
#(
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auth_done,
  input  logic          auth_grant,
  input  logic [KW-1:0] auth_key,
  input  logic          enc_done,
  input  logic          enc_ok,
  input  logic          mac_done,
  input  logic          mac_ok,
  output logic [1:0]    mode,
  output logic [KW-1:0] key_q,
  output logic          mac_bad
);
  sec_mode_e     mode_q, mode_d;
  logic [KW-1:0] key_d;
  logic          upd_en;

  assign mac_bad = mac_done && !mac_ok && (mode_q != MODE_STD);
  assign upd_en  = mac_bad || enc_done || auth_done;

  always_comb begin
    mode_d = mode_q;
    key_d  = key_q;
    if (mac_bad) begin
      mode_d = MODE_STD;
    end else if (enc_done && (mode_q != MODE_STD)) begin
      mode_d = enc_ok ? MODE_ENC : MODE_STD;
    end
    if (auth_done) begin
      if (auth_grant) begin
        mode_d = MODE_AUTH;
        key_d  = auth_key;
      end else begin
        mode_d = MODE_STD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STD;
      key_q  <= '0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      key_q  <= key_d;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/sec_pw_state.sv
// The single active password set and its right.
module sec_pw_state #(
  parameter int PW_IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pw_done,
  input  logic             pw_grant,
  input  logic [PW_IW-1:0] pw_set,
  input  logic             pw_is_write,
  output logic             valid_q,
  output logic [PW_IW-1:0] set_q,
  output logic             wr_q
);
  logic             valid_d, wr_d;
  logic [PW_IW-1:0] set_d;

  always_comb begin
    valid_d = pw_grant;
    set_d   = pw_grant ? pw_set : set_q;
    wr_d    = pw_grant && pw_is_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      set_q   <= '0;
      wr_q    <= 1'b0;
    end else if (pw_done) begin
      valid_q <= valid_d;
      set_q   <= set_d;
      wr_q    <= wr_d;
    end
  end
endmodule

// File: rtl/sec_zone_check.sv
// Per-zone access decision, selected by the queried zone.
module sec_zone_check
  import sec_priv_pkg::*;
#(
  parameter int NZ    = 8,
  parameter int PW_IW = 3,
  parameter int KW    = 2,
  localparam int ZW   = (NZ > 1) ? $clog2(NZ) : 1,
  localparam int ZL   = 1 << ZW
) (
  input  logic [1:0]          mode,
  input  logic [KW-1:0]       key_q,
  input  logic                pw_valid,
  input  logic [PW_IW-1:0]    pw_set_q,
  input  logic                pw_wr,
  input  logic                sup_en,
  input  logic [PW_IW-1:0]    sup_set,
  input  logic [NZ-1:0]       zone_pw_req,
  input  logic [NZ*PW_IW-1:0] zone_pw_set,
  input  logic [NZ-1:0]       zone_auth_req,
  input  logic [NZ*KW-1:0]    zone_key,
  input  logic [NZ-1:0]       zone_enc_req,
  input  logic [ZW-1:0]       q_zone,
  output logic                rd_allow,
  output logic                wr_allow
);
  logic          sup_hit;
  logic [NZ-1:0] rd_v, wr_v;

  assign sup_hit = sup_en && pw_valid && pw_wr && (pw_set_q == sup_set);

  for (genvar z = 0; z < NZ; z++) begin : g_zone
    logic [PW_IW-1:0] zset;
    logic [KW-1:0]    zkey;
    logic             pw_match, pw_rd_ok, pw_wr_ok, auth_ok, enc_ok;

    assign zset     = zone_pw_set[z*PW_IW +: PW_IW];
    assign zkey     = zone_key[z*KW +: KW];
    assign pw_match = pw_valid && ((pw_set_q == zset) || sup_hit);
    assign pw_rd_ok = !zone_pw_req[z] || pw_match;
    assign pw_wr_ok = !zone_pw_req[z] || (pw_match && pw_wr);
    assign auth_ok  = !zone_auth_req[z] ||
                      ((mode != MODE_STD) && (key_q == zkey));
    assign enc_ok   = !zone_enc_req[z] ||
                      ((mode == MODE_ENC) && (key_q == zkey));
    assign rd_v[z]  = pw_rd_ok && auth_ok && enc_ok;
    assign wr_v[z]  = pw_wr_ok && auth_ok && enc_ok;
  end

  logic [ZL-1:0] rd_ext, wr_ext;
  assign rd_ext   = ZL'(rd_v);
  assign wr_ext   = ZL'(wr_v);
  assign rd_allow = rd_ext[q_zone];
  assign wr_allow = wr_ext[q_zone];
endmodule

// File: rtl/sec_priv_tracker.sv
module sec_priv_tracker #(
  parameter int NUM_PW_SETS   = 8,
  parameter int NUM_KEY_SETS  = 4,
  parameter int NUM_ZONES     = 8,
  parameter int CNT_W         = 4,
  parameter int ATTEMPT_LIMIT = 3,
  localparam int PW_IW = (NUM_PW_SETS > 1) ? $clog2(NUM_PW_SETS) : 1,
  localparam int KW    = (NUM_KEY_SETS > 1) ? $clog2(NUM_KEY_SETS) : 1,
  localparam int ZW    = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       auth_done,
  input  logic                       auth_ok,
  input  logic [KW-1:0]              auth_key,
  input  logic                       enc_done,
  input  logic                       enc_ok,
  input  logic                       pw_done,
  input  logic                       pw_ok,
  input  logic                       pw_is_write,
  input  logic [PW_IW-1:0]           pw_set,
  input  logic                       mac_done,
  input  logic                       mac_ok,
  input  logic                       sup_en,
  input  logic [PW_IW-1:0]           sup_set,
  input  logic [NUM_ZONES-1:0]       zone_pw_req,
  input  logic [NUM_ZONES*PW_IW-1:0] zone_pw_set,
  input  logic [NUM_ZONES-1:0]       zone_auth_req,
  input  logic [NUM_ZONES*KW-1:0]    zone_key,
  input  logic [NUM_ZONES-1:0]       zone_enc_req,
  input  logic [ZW-1:0]              q_zone,
  output logic [1:0]                 mode,
  output logic [KW-1:0]              key_active,
  output logic                       pw_valid,
  output logic [PW_IW-1:0]           pw_active_set,
  output logic                       pw_write,
  output logic                       cmd_abort,
  output logic                       rd_allow,
  output logic                       wr_allow
);
  logic pw_grant, auth_grant;

  sec_attempt_bank #(
    .N(NUM_PW_SETS), .CW(CNT_W), .LIMIT(ATTEMPT_LIMIT)
  ) u_pw_cnt (
    .clk(clk), .rst_n(rst_n), .try_en(pw_done), .try_idx(pw_set),
    .try_ok(pw_ok), .grant(pw_grant)
  );

  sec_attempt_bank #(
    .N(NUM_KEY_SETS), .CW(CNT_W), .LIMIT(ATTEMPT_LIMIT)
  ) u_key_cnt (
    .clk(clk), .rst_n(rst_n), .try_en(auth_done), .try_idx(auth_key),
    .try_ok(auth_ok), .grant(auth_grant)
  );

  sec_mode_fsm #(.KW(KW)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .auth_done(auth_done), .auth_grant(auth_grant), .auth_key(auth_key),
    .enc_done(enc_done), .enc_ok(enc_ok),
    .mac_done(mac_done), .mac_ok(mac_ok),
    .mode(mode), .key_q(key_active), .mac_bad(cmd_abort)
  );

  sec_pw_state #(.PW_IW(PW_IW)) u_pw (
    .clk(clk), .rst_n(rst_n),
    .pw_done(pw_done), .pw_grant(pw_grant), .pw_set(pw_set),
    .pw_is_write(pw_is_write),
    .valid_q(pw_valid), .set_q(pw_active_set), .wr_q(pw_write)
  );

  sec_zone_check #(.NZ(NUM_ZONES), .PW_IW(PW_IW), .KW(KW)) u_zone (
    .mode(mode), .key_q(key_active),
    .pw_valid(pw_valid), .pw_set_q(pw_active_set), .pw_wr(pw_write),
    .sup_en(sup_en), .sup_set(sup_set),
    .zone_pw_req(zone_pw_req), .zone_pw_set(zone_pw_set),
    .zone_auth_req(zone_auth_req), .zone_key(zone_key),
    .zone_enc_req(zone_enc_req), .q_zone(q_zone),
    .rd_allow(rd_allow), .wr_allow(wr_allow)
  );
endmodule

// File: rtl/sec_priv_tracker_chk.sv
module sec_priv_tracker_chk #(
  parameter int NZ = 8,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auth_done,
  input logic          auth_ok,
  input logic          pw_done,
  input logic          pw_ok,
  input logic          mac_done,
  input logic          mac_ok,
  input logic [NZ-1:0] zone_enc_req,
  input logic [ZW-1:0] q_zone,
  input logic [1:0]    mode,
  input logic          pw_valid,
  input logic          cmd_abort,
  input logic          rd_allow,
  input logic          wr_allow
);
  // R2: encrypted mode is never entered straight from plain mode
  assert_enc_needs_auth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (mode != 2'd2));

  // R8: a failed authentication leaves plain mode
  assert_auth_fail_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_done && !auth_ok) |=> (mode == 2'd0));

  // R6: a failed password clears the active set
  assert_pw_fail_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_done && !pw_ok) |=> !pw_valid);

  // R4: write access always carries read access
  assert_write_implies_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> rd_allow);

  // R11: an encrypted-only zone is readable only in encrypted mode
  assert_enc_zone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_allow && zone_enc_req[q_zone]) |-> (mode == 2'd2));

  // R10: a mismatch with no authentication beside it drops to plain mode
  assert_mac_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_done && !mac_ok && (mode != 2'd0) && !auth_done) |=> (mode == 2'd0));

  // R10: abort only arises while privileged
  assert_abort_privileged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> (mode != 2'd0));
endmodule

bind sec_priv_tracker sec_priv_tracker_chk #(.NZ(NUM_ZONES)) u_chk (
  .clk(clk), .rst_n(rst_n), .auth_done(auth_done), .auth_ok(auth_ok),
  .pw_done(pw_done), .pw_ok(pw_ok), .mac_done(mac_done), .mac_ok(mac_ok),
  .zone_enc_req(zone_enc_req), .q_zone(q_zone), .mode(mode),
  .pw_valid(pw_valid), .cmd_abort(cmd_abort), .rd_allow(rd_allow),
  .wr_allow(wr_allow)
);

// File: tb/sec_priv_tracker_test.sv
`timescale 1ns/1ps
module sec_priv_tracker_test;
  localparam int NPW = 8, NKEY = 4, NZ = 8, LIM = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic auth_done, auth_ok, enc_done, enc_ok, pw_done, pw_ok, pw_is_write;
  logic mac_done, mac_ok, sup_en;
  logic [1:0] auth_key;
  logic [2:0] pw_set, sup_set, q_zone;
  logic [NZ-1:0] zone_pw_req, zone_auth_req, zone_enc_req;
  logic [NZ*3-1:0] zone_pw_set;
  logic [NZ*2-1:0] zone_key;
  logic [1:0] mode, key_active;
  logic pw_valid, pw_write, cmd_abort, rd_allow, wr_allow;
  logic [2:0] pw_active_set;

  int checks = 0, errors = 0, cyc = 0;

  sec_priv_tracker #(.NUM_PW_SETS(NPW), .NUM_KEY_SETS(NKEY), .NUM_ZONES(NZ),
                     .CNT_W(4), .ATTEMPT_LIMIT(LIM)) uut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    auth_done = 0; enc_done = 0; pw_done = 0; mac_done = 0;
  endtask

  task automatic pw_try(int s, int w, int ok);
    pw_set = 3'(s); pw_is_write = w[0]; pw_ok = ok[0]; pw_done = 1;
    @(negedge clk); idle();
  endtask

  task automatic auth_try(int k, int ok);
    auth_key = 2'(k); auth_ok = ok[0]; auth_done = 1;
    @(negedge clk); idle();
  endtask

  task automatic enc_try(int ok);
    enc_ok = ok[0]; enc_done = 1;
    @(negedge clk); idle();
  endtask

  task automatic do_reset();
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic cfg_pw_zones();
    for (int z = 0; z < NZ; z++) begin
      zone_pw_set[z*3 +: 3] = 3'(z);
      zone_key[z*2 +: 2]    = 2'(z % 4);
    end
    zone_pw_req = '1; zone_auth_req = '0; zone_enc_req = '0;
  endtask

  // expected read/write of every zone under password binding zone z -> set z
  task automatic sweep_pw(string tag, int act_set, int wr, int sup);
    for (int z = 0; z < NZ; z++) begin
      int er, ew;
      q_zone = 3'(z); #1;
      er = (sup != 0) || (act_set == z);
      ew = (sup != 0) || ((act_set == z) && (wr != 0));
      check({tag, " rd"}, int'(rd_allow), er);
      check({tag, " wr"}, int'(wr_allow), ew);
    end
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); auth_ok = 0; enc_ok = 0; pw_ok = 0; pw_is_write = 0;
    mac_ok = 0; sup_en = 0; sup_set = 3'd7; auth_key = 0; pw_set = 0; q_zone = 0;
    cfg_pw_zones();
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1 mode in reset", int'(mode), 0);
    rst_n = 1; @(negedge clk);
    check("R1 mode", int'(mode), 0);
    check("R1 pw_valid", int'(pw_valid), 0);
    sweep_pw("R1", -1, 0, 0);
    zone_pw_req = '0; q_zone = 3'd2; #1;
    check("R1 open zone rd", int'(rd_allow), 1);
    check("R1 open zone wr", int'(wr_allow), 1);
    zone_pw_req = '1;

    // R3 R4 R5: every set, both rights, every zone
    for (int s = 0; s < NPW; s++)
      for (int w = 0; w < 2; w++) begin
        pw_try(s, w, 1);
        check("R3 pw_valid", int'(pw_valid), 1);
        check("R3 active set", int'(pw_active_set), s);
        check("R3 write right", int'(pw_write), w);
        sweep_pw("R5 R4 sweep", s, w, 0);
      end

    // R6: failed password on another set clears the active one
    pw_try(2, 1, 1);
    pw_try(5, 1, 0);
    check("R6 pw_valid after fail", int'(pw_valid), 0);
    sweep_pw("R6", -1, 0, 0);

    // R9: supervisor
    sup_en = 1;
    pw_try(7, 1, 1);
    sweep_pw("R9 sup write", 7, 1, 1);
    pw_try(7, 0, 1);
    sweep_pw("R9 sup read", 7, 0, 0);
    sup_en = 0;
    pw_try(7, 1, 1);
    sweep_pw("R9 sup off", 7, 1, 0);

    // R2 R11: key and mode sweep over auth/enc zones
    zone_pw_req = '0; zone_auth_req = '1;
    zone_enc_req = 8'hF0;
    q_zone = 0; #1;
    check("R11 plain blocks auth zone", int'(rd_allow), 0);
    enc_try(1);
    check("R2 enc in plain ignored", int'(mode), 0);
    for (int k = 0; k < NKEY; k++) begin
      auth_try(k, 1);
      check("R8 auth mode", int'(mode), 1);
      check("R8 auth key", int'(key_active), k);
      for (int z = 0; z < NZ; z++) begin
        q_zone = 3'(z); #1;
        check("R11 auth rd", int'(rd_allow), int'(z < 4 && z % 4 == k));
        check("R11 auth wr", int'(wr_allow), int'(z < 4 && z % 4 == k));
      end
      enc_try(1);
      check("R2 enc mode", int'(mode), 2);
      for (int z = 0; z < NZ; z++) begin
        q_zone = 3'(z); #1;
        check("R11 enc rd", int'(rd_allow), int'(z % 4 == k));
      end
    end
    enc_try(0);
    check("R2 failed enc drops", int'(mode), 0);

    // R8: failed re-authentication cancels
    auth_try(1, 1); enc_try(1);
    auth_try(2, 0);
    check("R8 fail cancels", int'(mode), 0);

    // R10: MAC behaviour
    pw_try(3, 1, 1);
    auth_try(1, 1);
    mac_ok = 1; mac_done = 1; @(negedge clk); idle();
    check("R10 match no effect", int'(mode), 1);
    mac_ok = 0; mac_done = 1; #1;
    check("R10 abort raised", int'(cmd_abort), 1);
    @(negedge clk); idle();
    check("R10 mismatch drops", int'(mode), 0);
    check("R10 password kept", int'(pw_valid), 1);
    mac_done = 1; #1;
    check("R10 no abort in plain", int'(cmd_abort), 0);
    @(negedge clk); idle();
    check("R10 plain unchanged", int'(mode), 0);

    // R12: same-cycle priority
    auth_try(0, 1); enc_try(1);
    auth_key = 2'd3; auth_ok = 1; auth_done = 1; mac_ok = 0; mac_done = 1;
    @(negedge clk); idle();
    check("R12 auth over mac mode", int'(mode), 1);
    check("R12 auth over mac key", int'(key_active), 3);
    enc_ok = 1; enc_done = 1; mac_done = 1;
    @(negedge clk); idle();
    check("R12 mac cancels enc", int'(mode), 0);
    auth_key = 2'd2; auth_ok = 1; auth_done = 1; enc_ok = 1; enc_done = 1;
    @(negedge clk); idle();
    check("R12 auth over enc", int'(mode), 1);
    auth_key = 2'd2; auth_ok = 0; auth_done = 1; enc_done = 1;
    @(negedge clk); idle();
    check("R12 failed auth over enc", int'(mode), 0);

    // R7: password counters, reload and lockout for every set
    do_reset();
    for (int s = 0; s < NPW; s++) begin
      for (int i = 0; i < LIM - 1; i++) pw_try(s, 0, 0);
      pw_try(s, 0, 1);
      check("R7 grant before limit", int'(pw_valid), 1);
      for (int i = 0; i < LIM - 1; i++) pw_try(s, 0, 0);
      pw_try(s, 0, 1);
      check("R7 reload on success", int'(pw_valid), 1);
      for (int i = 0; i < LIM; i++) pw_try(s, 0, 0);
      pw_try(s, 1, 1);
      check("R7 locked refuses", int'(pw_valid), 0);
      pw_try(s, 1, 1);
      check("R7 stays locked", int'(pw_valid), 0);
    end
    // R7: key counters
    for (int k = 0; k < NKEY; k++) begin
      for (int i = 0; i < LIM; i++) auth_try(k, 0);
      auth_try(k, 1);
      check("R7 key locked", int'(mode), 0);
    end
    // R1: reset reloads counters
    do_reset();
    pw_try(4, 1, 1);
    check("R1 reset reloads pw counter", int'(pw_valid), 1);
    auth_try(2, 1);
    check("R1 reset reloads key counter", int'(mode), 1);
    rst_n = 0; #1;
    check("R1 async reset mode", int'(mode), 0);
    check("R1 async reset pw", int'(pw_valid), 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule